// File: doc/BRIEF.md
# Programmable Reference Divider for a Synthesizer Comparison Clock

This block runs in the reference clock domain (2 to 20 MHz) of a frequency synthesizer. It divides that clock down to the rate at which the phase comparator works. A 5-bit ratio code picks the division ratio from 29 legal values. The values fall into four families: plain powers of two, and powers of two multiplied by 5, 6 or 7. Three codes have no ratio. Such a code raises a flag, and the divider keeps running at the last legal ratio. A new ratio is taken up only at the end of the period in progress, so the comparator never sees a shortened cycle.

The block drives two forms of the comparison clock. One is a single-cycle pulse at the start of every period, for the phase comparator. The other is a square wave that is high for the first half of each period. A general-purpose port output is also provided. Three test bits choose what drives it: a static port bit, a divide-by-two of the feedback divider's pulse train, or the comparison square wave. This lets either side of the loop be watched from outside the chip.

Top module: `ref_divider`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fcomp_pulse`, `fcomp_sq`, `port_out` and `code_illegal` are 0. The ratio in force after reset is 2.
- R2: The ratio code is split into a family field (bits 4:3) and an exponent field e (bits 2:0). Family 00 selects a ratio of 2 shifted left by e, for ratios 2 through 256.
- R3: Families 01, 10 and 11 with e from 1 to 7 select 5, 6 or 7 times 2^(e-1), for ratios 5..320, 6..384 and 7..448.
- R4: Codes 01000, 10000 and 11000 are illegal. `code_illegal` is 1 in the cycle after such a code is presented and 0 in the cycle after a legal code is presented. The ratio keeps its last legal value for as long as the illegal code is present.
- R5: A new legal code takes effect only when the current period ends. The period that starts in the same cycle as a code change still runs at the old ratio, and later periods run at the new one.
- R6: `fcomp_pulse` is high for exactly one cycle per period. Successive pulses are N cycles apart, where N is the ratio in force.
- R7: `fcomp_sq` is high for the first floor(N/2) cycles of each period, starting in the cycle that `fcomp_pulse` is high.
- R8: For test codes 000, 001, 010 and 011, `port_out` equals `port_bit` delayed by one clock.
- R9: For test code 100, `port_out` shows an internal toggle one clock later. The toggle starts at 0 after reset and flips in the cycle after each cycle in which `fb_pulse` is high.
- R10: For test codes 101, 110 and 111, `port_out` equals `fcomp_sq` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 5 | Division ratio code: family in bits 4:3, exponent in bits 2:0 |
| test_mode | input | 3 | Selects the source of the port output |
| port_bit | input | 1 | Static level for the port output in normal mode |
| fb_pulse | input | 1 | One-cycle pulse from the feedback (LO) divider, synchronous to `clk` |
| fcomp_pulse | output | 1 | One-cycle comparison pulse at the start of each period |
| fcomp_sq | output | 1 | Comparison square wave |
| port_out | output | 1 | Registered general-purpose port level |
| code_illegal | output | 1 | High while the presented ratio code has no ratio |

## Verification
The assertions take the following for granted about the inputs:
- `fb_pulse` is already synchronous to the reference clock.
- The ratio code is a level that software changes now and then. It is not a signal that toggles every cycle.

The stimulus keeps to this in three ways:
- It changes the ratio code only in the cycle in which a comparison pulse has just been seen, and then leaves the code alone for three full periods.
- It drives the feedback pulse for single cycles with idle cycles between them.
- It changes the test bits only when no period measurement is pending.

With this pacing, each period between two pulses can be matched against a single expected ratio.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int TEST_W = 3;

  typedef enum logic [1:0] {
    SRC_STATIC = 2'd0,
    SRC_FBHALF = 2'd1,
    SRC_CMPSQ  = 2'd2
  } port_src_e;

  // Test bits: 100 shows feedback/2, other codes with MSB set show the
  // comparison square wave, everything else shows the static port bit.
  function automatic port_src_e port_source(input logic [TEST_W-1:0] tsel);
    if (tsel == 3'b100)
      return SRC_FBHALF;
    else if (tsel[TEST_W-1])
      return SRC_CMPSQ;
    else
      return SRC_STATIC;
  endfunction

endpackage

// File: rtl/refdiv_code_decode.sv
module refdiv_code_decode #(
  parameter int EXP_W   = 3,
  parameter int CODE_W  = EXP_W + 2,
  parameter int RATIO_W = (1 << EXP_W) + 1
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio,
  output logic               legal
);

  logic [1:0]       family;
  logic [EXP_W-1:0] expo;
  logic [2:0]       mant;

  assign family = code[CODE_W-1:EXP_W];
  assign expo   = code[EXP_W-1:0];
  assign mant   = {1'b1, family};   // 5, 6, 7 for families 1..3

  always_comb begin
    if (family == 2'b00) begin
      legal = 1'b1;
      ratio = RATIO_W'(2) << expo;
    end else if (expo == '0) begin
      legal = 1'b0;
      ratio = '0;
    end else begin
      legal = 1'b1;
      ratio = RATIO_W'(mant) << (expo - 1'b1);
    end
  end

  always_comb begin
    if (legal) begin
      AST_LEGAL_RATIO_MIN : assert (ratio >= RATIO_W'(2)); // R2 R3
    end
  end

endmodule

// File: rtl/refdiv_period_counter.sv
module refdiv_period_counter #(
  parameter int RATIO_W     = 9,
  parameter int RESET_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] next_ratio,
  output logic               pulse_q,
  output logic               sq_q
);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] active_ratio;
  logic [RATIO_W-1:0] cnt_inc;
  logic               terminal;

  assign terminal = (cnt == active_ratio - 1'b1);
  assign cnt_inc  = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      active_ratio <= RATIO_W'(RESET_RATIO);
      pulse_q      <= 1'b0;
      sq_q         <= 1'b0;
    end else if (terminal) begin
      cnt          <= '0;
      active_ratio <= next_ratio;
      pulse_q      <= 1'b1;
      sq_q         <= 1'b1;
    end else begin
      cnt          <= cnt_inc;
      pulse_q      <= 1'b0;
      sq_q         <= (cnt_inc < (active_ratio >> 1));
    end
  end

  AST_CNT_IN_PERIOD : assert property (@(posedge clk) disable iff (rst)
    cnt < active_ratio); // R6

  AST_RATIO_SWAP_AT_END : assert property (@(posedge clk) disable iff (rst)
    !terminal |=> $stable(active_ratio)); // R5

  AST_PULSE_SINGLE : assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R6

  AST_SQ_HIGH_AT_PULSE : assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> sq_q); // R7

endmodule

// File: rtl/refdiv_fb_halver.sv
module refdiv_fb_halver (
  input  logic clk,
  input  logic rst,
  input  logic fb_pulse,
  output logic fb_half
);

  always_ff @(posedge clk) begin
    if (rst)
      fb_half <= 1'b0;
    else if (fb_pulse)
      fb_half <= ~fb_half;
  end

  AST_FB_TOGGLES : assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> (fb_half != $past(fb_half))); // R9

  AST_FB_HOLDS : assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |=> $stable(fb_half)); // R9

endmodule

// File: rtl/refdiv_port_select.sv
module refdiv_port_select
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [TEST_W-1:0] test_mode,
  input  logic              port_bit,
  input  logic              fb_half,
  input  logic              cmp_sq,
  output logic              port_q
);

  port_src_e src;
  assign src = port_source(test_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= 1'b0;
    end else begin
      unique case (src)
        SRC_FBHALF: port_q <= fb_half;
        SRC_CMPSQ:  port_q <= cmp_sq;
        default:    port_q <= port_bit;
      endcase
    end
  end

  AST_PORT_STATIC : assert property (@(posedge clk) disable iff (rst)
    (test_mode[TEST_W-1] == 1'b0) |=> (port_q == $past(port_bit))); // R8

  AST_PORT_CMP : assert property (@(posedge clk) disable iff (rst)
    (test_mode[TEST_W-1] && test_mode != 3'b100) |=> (port_q == $past(cmp_sq))); // R10

endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import refdiv_pkg::*;
#(
  parameter int EXP_W       = 3,
  parameter int RESET_RATIO = 2,
  localparam int CODE_W     = EXP_W + 2,
  localparam int RATIO_W    = (1 << EXP_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic [TEST_W-1:0] test_mode,
  input  logic              port_bit,
  input  logic              fb_pulse,
  output logic              fcomp_pulse,
  output logic              fcomp_sq,
  output logic              port_out,
  output logic              code_illegal
);

  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_legal;
  logic [RATIO_W-1:0] pending_ratio;
  logic               illegal_q;
  logic               fb_half;

  refdiv_code_decode #(
    .EXP_W   (EXP_W),
    .CODE_W  (CODE_W),
    .RATIO_W (RATIO_W)
  ) u_decode (
    .code  (ratio_code),
    .ratio (dec_ratio),
    .legal (dec_legal)
  );

  // Latest legal ratio; an illegal code leaves it untouched.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending_ratio <= RATIO_W'(RESET_RATIO);
      illegal_q     <= 1'b0;
    end else begin
      illegal_q <= ~dec_legal;
      if (dec_legal)
        pending_ratio <= dec_ratio;
    end
  end

  assign code_illegal = illegal_q;

  AST_ILLEGAL_KEEPS_RATIO : assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $stable(pending_ratio)); // R4

  AST_PENDING_NONZERO : assert property (@(posedge clk) disable iff (rst)
    pending_ratio >= RATIO_W'(2)); // R4

  refdiv_period_counter #(
    .RATIO_W     (RATIO_W),
    .RESET_RATIO (RESET_RATIO)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .next_ratio (pending_ratio),
    .pulse_q    (fcomp_pulse),
    .sq_q       (fcomp_sq)
  );

  refdiv_fb_halver u_fb_half (
    .clk      (clk),
    .rst      (rst),
    .fb_pulse (fb_pulse),
    .fb_half  (fb_half)
  );

  refdiv_port_select u_port (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .port_bit  (port_bit),
    .fb_half   (fb_half),
    .cmp_sq    (fcomp_sq),
    .port_q    (port_out)
  );

endmodule

// File: tb/ref_divider_bench.sv
module ref_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ratio_code = 5'b00000;
  logic [2:0] test_mode = 3'b000;
  logic       port_bit = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       fcomp_pulse, fcomp_sq, port_out, code_illegal;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  int cur_ratio = 2;
  int cyc = 0;
  int prev_pulse = 0;
  bit have_prev = 0;
  int hi_cnt = 0;
  bit last_pulse = 0;
  bit done = 0;
  event pulse_seen;

  always #5 clk = ~clk;

  ref_divider u_ref_divider (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .test_mode(test_mode),
    .port_bit(port_bit), .fb_pulse(fb_pulse), .fcomp_pulse(fcomp_pulse),
    .fcomp_sq(fcomp_sq), .port_out(port_out), .code_illegal(code_illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit tb_legal(input logic [4:0] c);
    return !((c[4:3] != 2'b00) && (c[2:0] == 3'b000));
  endfunction

  function automatic int tb_ratio(input logic [4:0] c);
    int r;
    int steps;
    if (c[4:3] == 2'b00) begin
      r = 2;
      steps = c[2:0];
    end else begin
      r = 4 + c[4:3];
      steps = c[2:0] - 1;
    end
    for (int k = 0; k < steps; k++) r = r * 2;
    return r;
  endfunction

  // Monitor / scoreboard: period and square-wave duty per pulse.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (fcomp_pulse) begin
        if (last_pulse) check(0, "R6 pulse wider than one cycle", 1, 0);
        if (have_prev) begin
          if (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check(cyc - prev_pulse == e, "R2/R3/R5 period", cyc - prev_pulse, e);
            check(hi_cnt == e / 2, "R7 square high cycles", hi_cnt, e / 2);
          end
        end
        check(fcomp_sq == 1'b1, "R7 square high at pulse", fcomp_sq, 1);
        have_prev = 1;
        prev_pulse = cyc;
        hi_cnt = 1;
        -> pulse_seen;
      end else if (fcomp_sq) begin
        hi_cnt++;
      end
      last_pulse = fcomp_pulse;
    end
  end

  task automatic apply_code(input logic [4:0] c);
    int nr;
    bit lg;
    @(pulse_seen);
    ratio_code = c;
    lg = tb_legal(c);
    nr = lg ? tb_ratio(c) : cur_ratio;
    exp_q.push_back(cur_ratio);
    exp_q.push_back(nr);
    exp_q.push_back(nr);
    cur_ratio = nr;
    @(negedge clk);
    check(code_illegal == !lg, "R4 illegal flag", code_illegal, !lg);
    repeat (3) @(pulse_seen);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fcomp_pulse == 0, "R1 pulse in reset", fcomp_pulse, 0);
    check(fcomp_sq == 0, "R1 square in reset", fcomp_sq, 0);
    check(port_out == 0, "R1 port in reset", port_out, 0);
    check(code_illegal == 0, "R1 flag in reset", code_illegal, 0);
    rst = 1'b0;
    @(negedge clk);
    check(fcomp_pulse == 0 && fcomp_sq == 0 && port_out == 0 && code_illegal == 0,
          "R1 first cycle after reset", {fcomp_pulse, fcomp_sq, port_out, code_illegal}, 0);
    // R1: default ratio 2 measured over two periods
    @(pulse_seen);
    exp_q.push_back(2);
    exp_q.push_back(2);
    repeat (2) @(pulse_seen);

    apply_code(5'b00011);  // R2 16
    apply_code(5'b01001);  // R3 5
    apply_code(5'b01011);  // R3 20
    apply_code(5'b10001);  // R3 6
    apply_code(5'b01000);  // R4 illegal, keeps 6
    apply_code(5'b11001);  // R3 7
    apply_code(5'b10000);  // R4 illegal, keeps 7
    apply_code(5'b11010);  // R3 14
    apply_code(5'b11000);  // R4 illegal, keeps 14
    apply_code(5'b00111);  // R2 256
    apply_code(5'b11111);  // R3 448
    apply_code(5'b10011);  // R3 24
    apply_code(5'b01001);  // R3 5 for port tests

    // R8 static port bit under test codes 000..011
    for (int t = 0; t < 4; t++) begin
      test_mode = 3'(t);
      port_bit = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(port_out == 1, "R8 port follows bit", port_out, 1);
      port_bit = 1'b0;
      @(negedge clk);
      check(port_out == 0, "R8 port follows bit", port_out, 0);
    end

    // R9 feedback divide-by-two
    test_mode = 3'b100;
    begin
      bit tog;
      tog = 0;
      @(negedge clk);
      @(negedge clk);
      check(port_out == tog, "R9 toggle idle", port_out, tog);
      for (int k = 0; k < 4; k++) begin
        fb_pulse = 1'b1;
        @(negedge clk);
        fb_pulse = 1'b0;
        tog = !tog;
        @(negedge clk);
        check(port_out == tog, "R9 toggle after fb pulse", port_out, tog);
        @(negedge clk);
        check(port_out == tog, "R9 toggle held", port_out, tog);
      end
    end

    // R10 comparison square wave on the port
    for (int t = 5; t < 8; t++) begin
      bit prev_sq;
      test_mode = 3'(t);
      @(negedge clk);
      prev_sq = fcomp_sq;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        check(port_out == prev_sq, "R10 port shows square", port_out, prev_sq);
        prev_sq = fcomp_sq;
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule